// File: doc/BRIEF.md
# Guarded Control-Register Write Sequencer

This block holds the nonvolatile control field of a supervisor: a two-bit watchdog period and three block-protect bits. It also owns the two volatile latches that guard writes to those fields. It sits behind a byte-level transaction front end, which reports a transaction opening (start or repeated start), each received data byte, and the closing stop. The block answers every byte with an acknowledge or a not-acknowledge and exposes the whole control register as one byte.

The fields can change only after a three-step unlock. Step one is a write of 02h, which arms the write latch. Step two is a write of 06h, which also arms the register-write latch. Step three is a value byte with bit 1 set and bit 2 clear, which commits the fields and starts a simulated nonvolatile write. That write holds the block busy for a parameterised number of clock cycles. A byte only takes effect when it was the single byte of a transaction that was closed by a stop. Read transactions pass through without disturbing the sequence. An external pulse that reports an attempted write to a protected memory block disarms the register-write latch.

Top module: `ctrl_reg_guard`

## Requirements
- R1: After reset, the write latch and the register-write latch are 0, busy is 0, and the fields hold the PWRUP_FIELDS parameter value {wd[1:0], bp[2:0]}.
- R2: With the register-write latch clear, committing 02h sets the write latch and starts no busy period. Committing 06h while the write latch is clear also only sets the write latch.
- R3: With the register-write latch clear and the write latch set, committing 06h sets the register-write latch and keeps the write latch set.
- R4: With the register-write latch set, committing a byte with bit 2 = 0 and bit 1 = 1 loads wd = byte[6:5] and bp = {byte[0], byte[4:3]}. It clears the register-write latch, keeps the write latch set and raises busy. The sequence 02h, 06h, 02h therefore zeroes all fields.
- R5: With the register-write latch set, committing a byte with bit 2 = 1 (06h included) leaves the fields unchanged and both latches set.
- R6: With the register-write latch set, committing a byte with bits 2 and 1 both 0 clears both latches and leaves the fields unchanged. With the register-write latch clear, committing any byte other than 02h or 06h clears the write latch.
- R7: The first byte of an open transaction is acknowledged (ack_o = 1 one cycle after the byte). Every further byte of the same transaction gets ack_o = 0, and the stop then commits nothing.
- R8: Busy stays high for exactly WR_CYCLES cycles after a field commit. A byte received while busy gets ack_o = 0, and its transaction commits nothing.
- R9: A pulse on prot_wr_i clears the register-write latch and leaves the write latch and the fields unchanged. It takes priority over a commit in the same cycle.
- R10: A read-transaction strobe changes no state, so a sequence interleaved with reads completes as it would without them.
- R11: A transaction reopened by a repeated start before its stop discards its byte. A stop with no transaction open has no effect. A byte with no transaction open gets ack_o = 0 and has no effect.
- R12: reg_o = {0, wd[1], wd[0], bp[1], bp[0], rwel, wel, bp[2]} at all times, so bit 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| txn_start_i | input | 1 | Start or repeated start of a control-register write transaction |
| txn_stop_i | input | 1 | Stop condition closing the transaction |
| byte_valid_i | input | 1 | A data byte is present on byte_i |
| byte_i | input | 8 | Received data byte |
| rd_txn_i | input | 1 | Strobe marking a read transaction |
| prot_wr_i | input | 1 | Strobe marking an attempted write to a protected block |
| reg_o | output | 8 | Control register readback |
| wel_o | output | 1 | Write latch state |
| rwel_o | output | 1 | Register-write latch state |
| ack_valid_o | output | 1 | ack_o is valid for the byte of the previous cycle |
| ack_o | output | 1 | 1 = acknowledge, 0 = not-acknowledge |
| busy_o | output | 1 | Simulated nonvolatile write in progress |

## Verification
The assertions check four properties on every cycle. The register-write latch never stands without the write latch. It can only rise from a state where the write latch was already set. The fields stay frozen while busy is high. Any second byte inside a transaction draws a not-acknowledge. The bench scenarios cover the properties that depend on what a sequence means: the 02h/06h/value unlock, the corrupted sequences that zero the fields or keep the latch armed, reads interleaved between steps, repeated-start discards, and the exact length of the busy window. A cycle-level reference model drives the random mix of overlapping starts, stops, bytes and protect pulses.

// File: rtl/crg_pkg.sv
package crg_pkg;
  typedef struct packed {
    logic [1:0] wd;
    logic [2:0] bp;
  } nv_fields_t;

  localparam logic [7:0] ARM_WEL_CODE  = 8'h02;
  localparam logic [7:0] ARM_RWEL_CODE = 8'h06;

  function automatic nv_fields_t fields_from_byte(input logic [7:0] b);
    nv_fields_t f;
    f.wd = b[6:5];
    f.bp = {b[0], b[4:3]};
    return f;
  endfunction

  function automatic logic [7:0] pack_reg(input nv_fields_t f, input logic rwel, input logic wel);
    return {1'b0, f.wd[1], f.wd[0], f.bp[1], f.bp[0], rwel, wel, f.bp[2]};
  endfunction
endpackage

// File: rtl/crg_txn_tracker.sv
module crg_txn_tracker (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       busy_i,
  output logic       commit_o,
  output logic [7:0] commit_byte_o,
  output logic       ack_valid_o,
  output logic       ack_o
);
  logic       open_q;
  logic [1:0] nbytes_q;
  logic       blocked_q;
  logic [7:0] byte_q;
  logic       byte_take;

  // priority: start, then stop, then byte
  assign byte_take = byte_valid_i && !start_i && !stop_i;
  assign commit_o  = open_q && !start_i && stop_i && (nbytes_q == 2'd1) && !blocked_q && !busy_i;
  assign commit_byte_o = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= 1'b0;
      nbytes_q    <= 2'd0;
      blocked_q   <= 1'b0;
      byte_q      <= 8'h00;
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      ack_valid_o <= byte_take;
      ack_o       <= 1'b0;
      if (start_i) begin
        open_q    <= 1'b1;
        nbytes_q  <= 2'd0;
        blocked_q <= 1'b0;
      end else if (stop_i) begin
        open_q <= 1'b0;
      end else if (byte_valid_i && open_q) begin
        ack_o <= !busy_i && (nbytes_q == 2'd0);
        if (nbytes_q != 2'd2) nbytes_q <= nbytes_q + 2'd1;
        if (nbytes_q == 2'd0) byte_q <= byte_i;
        if (busy_i) blocked_q <= 1'b1;
      end
    end
  end

  // R7
  second_byte_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_q && byte_take && nbytes_q != 2'd0) |=> (ack_valid_o && !ack_o));
endmodule

// File: rtl/crg_nv_timer.sv
module crg_nv_timer #(
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(WR_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(WR_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/crg_latch_ctrl.sv
module crg_latch_ctrl
  import crg_pkg::*;
#(
  parameter nv_fields_t PWRUP_FIELDS = 5'b01_010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic [7:0] byte_i,
  input  logic       prot_wr_i,
  output logic       wel_o,
  output logic       rwel_o,
  output nv_fields_t fields_o,
  output logic       nv_start_o
);
  logic       wel_q, rwel_q, wel_d, rwel_d;
  nv_fields_t fields_q, fields_d;

  always_comb begin
    wel_d      = wel_q;
    rwel_d     = rwel_q;
    fields_d   = fields_q;
    nv_start_o = 1'b0;
    if (commit_i) begin
      if (rwel_q) begin
        if (byte_i[2]) begin
          // latch stays armed, fields untouched
        end else if (byte_i[1]) begin
          fields_d   = fields_from_byte(byte_i);
          rwel_d     = 1'b0;
          wel_d      = 1'b1;
          nv_start_o = 1'b1;
        end else begin
          wel_d  = 1'b0;
          rwel_d = 1'b0;
        end
      end else if (byte_i == ARM_WEL_CODE) begin
        wel_d = 1'b1;
      end else if (byte_i == ARM_RWEL_CODE) begin
        wel_d  = 1'b1;
        rwel_d = wel_q;
      end else begin
        wel_d = 1'b0;
      end
    end
    if (prot_wr_i) rwel_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q    <= 1'b0;
      rwel_q   <= 1'b0;
      fields_q <= PWRUP_FIELDS;
    end else begin
      wel_q    <= wel_d;
      rwel_q   <= rwel_d;
      fields_q <= fields_d;
    end
  end

  assign wel_o    = wel_q;
  assign rwel_o   = rwel_q;
  assign fields_o = fields_q;

  // R3
  rwel_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rwel_q |-> wel_q);
  // R3
  rwel_rise_from_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rwel_q) |-> $past(wel_q));
endmodule

// File: rtl/ctrl_reg_guard.sv
module ctrl_reg_guard
  import crg_pkg::*;
#(
  parameter int unsigned WR_CYCLES    = 16,
  parameter logic [4:0]  PWRUP_FIELDS = 5'b01_010
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txn_start_i,
  input  logic       txn_stop_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       rd_txn_i,
  input  logic       prot_wr_i,
  output logic [7:0] reg_o,
  output logic       wel_o,
  output logic       rwel_o,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       busy_o
);
  logic       commit;
  logic [7:0] commit_byte;
  logic       nv_start;
  logic       rd_seen;
  nv_fields_t fields;

  // reads are transparent to the write sequence
  assign rd_seen = rd_txn_i;

  crg_txn_tracker u_txn (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (txn_start_i),
    .stop_i       (txn_stop_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .busy_i       (busy_o),
    .commit_o     (commit),
    .commit_byte_o(commit_byte),
    .ack_valid_o  (ack_valid_o),
    .ack_o        (ack_o)
  );

  crg_latch_ctrl #(.PWRUP_FIELDS(nv_fields_t'(PWRUP_FIELDS))) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .byte_i    (commit_byte),
    .prot_wr_i (prot_wr_i),
    .wel_o     (wel_o),
    .rwel_o    (rwel_o),
    .fields_o  (fields),
    .nv_start_o(nv_start)
  );

  crg_nv_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(nv_start),
    .busy_o (busy_o)
  );

  assign reg_o = pack_reg(fields, rwel_o, wel_o);

  // R8
  frozen_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(fields));
  // R4
  busy_rise_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!rwel_o && wel_o));
  // R10
  read_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_seen && !txn_start_i && !txn_stop_i && !byte_valid_i && !prot_wr_i && !busy_o)
      |=> $stable(reg_o));
endmodule

// File: tb/tb_ctrl_reg_guard.sv
module tb_ctrl_reg_guard;
  localparam int unsigned WR = 12;
  localparam logic [4:0] PWR = 5'b01_010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st = 0, sp = 0, bv = 0, rd = 0, pr = 0;
  logic [7:0] b = 8'h00;
  logic [7:0] reg_o;
  logic wel_o, rwel_o, ack_valid_o, ack_o, busy_o;

  int checks = 0, errors = 0;

  // reference model state
  bit m_wel, m_rwel, m_open, m_blk, m_av, m_ack;
  bit [4:0] m_f;
  bit [7:0] m_byte;
  int m_n, m_busy;

  always #5 clk = ~clk;

  ctrl_reg_guard #(.WR_CYCLES(WR), .PWRUP_FIELDS(PWR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .txn_start_i(st), .txn_stop_i(sp),
    .byte_valid_i(bv), .byte_i(b), .rd_txn_i(rd), .prot_wr_i(pr),
    .reg_o(reg_o), .wel_o(wel_o), .rwel_o(rwel_o),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o), .busy_o(busy_o)
  );

  function automatic bit [7:0] exp_reg(bit [4:0] f, bit rw, bit w);
    return {1'b0, f[4], f[3], f[1], f[0], rw, w, f[2]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit s, bit p, bit v, bit [7:0] d, bit prot);
    bit busy = (m_busy != 0);
    bit commit = m_open && !s && p && (m_n == 1) && !m_blk && !busy;
    bit nw = m_wel, nr = m_rwel, nvs = 0;
    bit [4:0] nf = m_f;
    if (commit) begin
      if (m_rwel) begin
        if (m_byte[2]) ;
        else if (m_byte[1]) begin nf = {m_byte[6:5], m_byte[0], m_byte[4:3]}; nr = 0; nw = 1; nvs = 1; end
        else begin nw = 0; nr = 0; end
      end else if (m_byte == 8'h02) nw = 1;
      else if (m_byte == 8'h06) begin nw = 1; nr = m_wel; end
      else nw = 0;
    end
    if (prot) nr = 0;
    m_av = v && !s && !p;
    m_ack = 0;
    if (s) begin m_open = 1; m_n = 0; m_blk = 0; end
    else if (p) m_open = 0;
    else if (v && m_open) begin
      m_ack = !busy && (m_n == 0);
      if (m_n == 0) m_byte = d;
      if (m_n < 2) m_n++;
      if (busy) m_blk = 1;
    end
    if (nvs) m_busy = WR; else if (m_busy > 0) m_busy--;
    m_wel = nw; m_rwel = nr; m_f = nf;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(string tag, bit s, bit p, bit v, bit [7:0] d, bit r, bit prot);
    st = s; sp = p; bv = v; b = d; rd = r; pr = prot;
    @(posedge clk);
    model_edge(s, p, v, d, prot);
    @(negedge clk);
    st = 0; sp = 0; bv = 0; rd = 0; pr = 0;
    chk({tag, " R12 reg"}, 32'(reg_o), 32'(exp_reg(m_f, m_rwel, m_wel)));
    chk({tag, " busy"}, 32'(busy_o), 32'(m_busy != 0));
    chk({tag, " ackv"}, 32'(ack_valid_o), 32'(m_av));
    if (m_av) chk({tag, " ack"}, 32'(ack_o), 32'(m_ack));
  endtask

  task automatic wr(string tag, bit [7:0] d);
    step(tag, 1, 0, 0, 0, 0, 0);
    step(tag, 0, 0, 1, d, 0, 0);
    step(tag, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int bc;
    void'($urandom(32'd1234));
    m_f = PWR; m_wel = 0; m_rwel = 0; m_open = 0; m_n = 0; m_blk = 0; m_busy = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reg", 32'(reg_o), 32'(exp_reg(PWR, 0, 0)));
    chk("R1 busy", 32'(busy_o), 0);
    rst_n = 1;
    @(negedge clk);

    wr("R2", 8'h02);
    chk("R2 wel", 32'(wel_o), 1);
    wr("R3", 8'h06);
    chk("R3 rwel", 32'(rwel_o), 1);
    wr("R4", 8'h5B);
    chk("R4 fields", 32'(reg_o), 32'(8'h5B & 8'h7B) | 32'h02);
    chk("R4 rwel", 32'(rwel_o), 0);
    bc = 1;
    while (busy_o && bc < 100) begin
      // R8: write attempt inside busy window is refused
      if (bc == 2) begin
        step("R8", 1, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 1, 8'h06, 0, 0);
        chk("R8 nack", 32'(ack_o), 0);
        step("R8", 0, 1, 0, 0, 0, 0);
        bc += 3;
      end else begin
        idle("R8", 1);
        if (busy_o) bc++;
      end
    end
    chk("R8 busy length", 32'(bc), 32'(WR));

    wr("R5", 8'h02); wr("R5", 8'h06); wr("R5", 8'h06);
    chk("R5 rwel kept", 32'(rwel_o), 1);
    wr("R5", 8'h7E);
    chk("R5 fields kept", 32'(reg_o), 32'h5F);

    // R7: two bytes in one transaction
    step("R7", 1, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 1, 8'h02, 0, 0);
    chk("R7 first ack", 32'(ack_o), 1);
    step("R7", 0, 0, 1, 8'h02, 0, 0);
    chk("R7 second nack", 32'(ack_o), 0);
    step("R7", 0, 1, 0, 0, 0, 0);
    chk("R7 no commit", 32'(reg_o), 32'h5F);

    wr("R4 zero", 8'h02);
    chk("R4 zeroed", 32'(reg_o), 32'h02);
    idle("R4", WR + 1);

    // R10: reads between steps
    wr("R10", 8'h02); step("R10", 0, 0, 0, 0, 1, 0);
    wr("R10", 8'h06); step("R10", 0, 0, 0, 0, 1, 0);
    chk("R10 armed", 32'(rwel_o), 1);
    wr("R10", 8'h2B);
    chk("R10 commit", 32'(reg_o), 32'h2B);
    idle("R10", WR + 1);

    // R9
    wr("R9", 8'h06);
    chk("R9 armed", 32'(rwel_o), 1);
    step("R9", 0, 0, 0, 0, 0, 1);
    chk("R9 rwel", 32'(rwel_o), 0);
    chk("R9 wel", 32'(wel_o), 1);

    // R6
    wr("R6", 8'h06);
    wr("R6", 8'h00);
    chk("R6 both cleared", 32'({wel_o, rwel_o}), 0);
    wr("R6", 8'h02); wr("R6", 8'h55);
    chk("R6 wel cleared", 32'(wel_o), 0);

    // R11: restart discards, stray stop and stray byte ignored
    step("R11", 1, 0, 0, 0, 0, 0);
    step("R11", 0, 0, 1, 8'h02, 0, 0);
    step("R11", 1, 0, 0, 0, 0, 0);
    step("R11", 0, 1, 0, 0, 0, 0);
    chk("R11 restart", 32'(wel_o), 0);
    step("R11", 0, 1, 0, 0, 0, 0);
    step("R11", 0, 0, 1, 8'h02, 0, 0);
    chk("R11 stray nack", 32'(ack_o), 0);
    chk("R11 no effect", 32'(wel_o), 0);

    // R2: 06h without write latch sets only the write latch
    wr("R2", 8'h06);
    chk("R2 06 alone", 32'({wel_o, rwel_o}), 32'b10);

    for (int i = 0; i < 3000; i++) begin
      bit [7:0] d;
      case ($urandom % 4)
        0: d = 8'h02;
        1: d = 8'h06;
        2: d = (8'($urandom) & 8'h7B) | 8'h02;
        default: d = 8'($urandom);
      endcase
      step("rand", ($urandom % 7) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0, d,
           ($urandom % 9) == 0, ($urandom % 31) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule